// File: doc/BRIEF.md
# Printer Port Register Interface

This block is the host-facing register set of a legacy byte-wide printer port. A simple synchronous bus (address, write data, write enable, read enable, read data) reaches three registers: a data byte, a status byte and a control byte. No real printer is attached. The block models the printer side of the handshake itself. Status reads and strobe edges in control writes move the busy and acknowledge bits through their sequence, as a polling driver expects.

When the host releases the strobe after asserting it, the block presents the data byte on an output bus with a one-clock valid pulse. Reverse-direction reads come from an input byte latch. The latch loads from a separate input whenever its load strobe is high. A level interrupt is raised when the host asserts the strobe while interrupts are enabled. The interrupt stays high until the host reads status.

Read data is combinational from the addressed register. Every read side effect and every write takes effect at the clock edge that ends the access. The bus carries one address per cycle, so one cycle cannot hold both a status read and a control write.

Top module: `lpt_regif`

## Requirements
- R1: After reset the status byte reads 0xD9, the control byte reads 0xCC, the data byte reads 0xFF, and irq and out_valid are low.
- R2: The offset on bus_addr selects the register: 0 data, 1 status, 2 control. Offsets 3 to 7 read 0xFF. Writes to offsets 1 and 3 to 7 change nothing that can be read.
- R3: A control write stores the written value with bits 7 and 6 forced to 1.
- R4: A control write with bit 2 (init, active low) at 0 reloads status to 0xD8: busy-inverted bit 7, ack bit 6, online bit 4 and error-inverted bit 3 set, all others clear.
- R5: A control write with bit 2 = 1, bit 3 (select) = 1 and bit 0 (strobe, active low) = 1 clears status bit 7. If the stored bit 0 was 0, the data byte appears on out_byte with out_valid high for exactly the next clock. With bit 3 = 0 neither happens.
- R6: A control write with bit 2 = 1, bit 3 = 1 and bit 0 = 0 sets the interrupt-pending flag only if the previously stored control bit 4 (interrupt enable) was 1.
- R7: A data-offset read returns the input latch when stored control bit 5 (direction) is 1, and the last written data byte otherwise.
- R8: A status read returns the status held before the edge and clears interrupt-pending. If status bit 7 is 0 and stored control bit 0 is 0, it toggles bit 6. When it sets bit 6, it also sets bit 7.
- R9: irq is a level that is high from the clock after pending is set until the clock after a status read clears it.
- R10: rev_load captures rev_data into the input latch at the clock edge. A data read in the same cycle returns the previously latched byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write enable |
| bus_re | input | 1 | Read enable (gates read side effects) |
| bus_rdata | output | 8 | Read data, combinational from the addressed register |
| rev_data | input | 8 | Reverse-direction input byte |
| rev_load | input | 1 | Load strobe for the input latch |
| out_byte | output | 8 | Byte sent on a strobe release |
| out_valid | output | 1 | One-clock pulse qualifying out_byte |
| irq | output | 1 | Level interrupt |

## Verification
Two functions can land in the same cycle: a reverse-byte load and a data-offset read in input direction. The bench raises rev_load together with a data read. The read in that cycle must still show the old latched byte, and the next read must show the new one. A status read that both clears a pending interrupt and toggles the acknowledge bit is the other coincidence. It is judged by reading status on consecutive cycles and checking irq together with each returned byte.

// File: rtl/lpt_pkg.sv
package lpt_pkg;

    localparam int BYTE_W = 8;
    localparam int SEL_W  = 3;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [SEL_W-1:0]  sel_t;

    localparam sel_t SEL_DATA = 3'd0;
    localparam sel_t SEL_STAT = 3'd1;
    localparam sel_t SEL_CTRL = 3'd2;

    // status bit positions
    localparam int ST_BUSY_N = 7;
    localparam int ST_ACK    = 6;
    localparam int ST_PAPER  = 5;
    localparam int ST_ONLINE = 4;
    localparam int ST_ERR_N  = 3;
    localparam int ST_TMO    = 0;

    // control bit positions
    localparam int CT_DIR    = 5;
    localparam int CT_IRQEN  = 4;
    localparam int CT_SEL_N  = 3;
    localparam int CT_INIT_N = 2;
    localparam int CT_AFD_N  = 1;
    localparam int CT_STB_N  = 0;

    localparam byte_t STATUS_RST  = 8'hD9;
    localparam byte_t STATUS_INIT = 8'hD8;
    localparam byte_t CTRL_RST    = 8'hCC;
    localparam byte_t DATA_RST    = 8'hFF;
    localparam byte_t UNMAPPED    = 8'hFF;
    localparam byte_t CTRL_FORCE  = 8'hC0;

    typedef struct packed {
        logic wr_data;
        logic wr_ctrl;
        logic rd_stat;
    } bus_op_t;

    function automatic byte_t ctrl_fold(byte_t v);
        return v | CTRL_FORCE;
    endfunction

    // emulated printer reaction to the host polling status
    function automatic byte_t status_after_read(byte_t st, logic stb_n);
        byte_t r;
        r = st;
        if (!st[ST_BUSY_N] && !stb_n) begin
            if (st[ST_ACK]) begin
                r[ST_ACK] = 1'b0;
            end else begin
                r[ST_ACK]    = 1'b1;
                r[ST_BUSY_N] = 1'b1;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/lpt_bus_decode.sv
module lpt_bus_decode
    import lpt_pkg::*;
(
    input  sel_t    addr,
    input  logic    we,
    input  logic    re,
    output bus_op_t op
);
    always_comb begin
        op         = '0;
        op.wr_data = we && (addr == SEL_DATA);
        op.wr_ctrl = we && (addr == SEL_CTRL);
        op.rd_stat = re && (addr == SEL_STAT);
    end
endmodule

// File: rtl/lpt_handshake.sv
module lpt_handshake
    import lpt_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  bus_op_t op,
    input  byte_t   wdata,
    output byte_t   status_q,
    output byte_t   ctrl_q,
    output logic    pend_q,
    output logic    emit
);
    byte_t st_n;
    byte_t ctrl_n;
    byte_t folded;
    logic  pend_n;

    always_comb begin
        st_n   = status_q;
        ctrl_n = ctrl_q;
        pend_n = pend_q;
        emit   = 1'b0;
        folded = ctrl_fold(wdata);
        if (op.rd_stat) begin
            st_n   = status_after_read(status_q, ctrl_q[CT_STB_N]);
            pend_n = 1'b0;
        end
        if (op.wr_ctrl) begin
            if (!folded[CT_INIT_N]) begin
                st_n = STATUS_INIT;
            end else if (folded[CT_SEL_N]) begin
                if (folded[CT_STB_N]) begin
                    st_n[ST_BUSY_N] = 1'b0;
                    emit            = !ctrl_q[CT_STB_N];
                end else if (ctrl_q[CT_IRQEN]) begin
                    pend_n = 1'b1;
                end
            end
            ctrl_n = folded;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= STATUS_RST;
            ctrl_q   <= CTRL_RST;
            pend_q   <= 1'b0;
        end else begin
            status_q <= st_n;
            ctrl_q   <= ctrl_n;
            pend_q   <= pend_n;
        end
    end

    // R4
    init_reload_chk: assert property (@(posedge clk) disable iff (rst)
        op.wr_ctrl && !wdata[CT_INIT_N] |=> status_q == STATUS_INIT);

    // R5
    busy_release_chk: assert property (@(posedge clk) disable iff (rst)
        op.wr_ctrl && wdata[CT_INIT_N] && wdata[CT_SEL_N] && wdata[CT_STB_N]
        |=> !status_q[ST_BUSY_N]);

    // R6
    pend_guard_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pend_q) |-> $past(ctrl_q[CT_IRQEN]));

    // R8
    pend_clear_chk: assert property (@(posedge clk) disable iff (rst)
        op.rd_stat |=> !pend_q);
endmodule

// File: rtl/lpt_datapath.sv
module lpt_datapath
    import lpt_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  bus_op_t op,
    input  byte_t   wdata,
    input  byte_t   rev_data,
    input  logic    rev_load,
    input  logic    emit,
    output byte_t   dataw_q,
    output byte_t   datar_q,
    output byte_t   out_byte_q,
    output logic    out_valid_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            dataw_q     <= DATA_RST;
            datar_q     <= DATA_RST;
            out_byte_q  <= DATA_RST;
            out_valid_q <= 1'b0;
        end else begin
            if (op.wr_data) dataw_q <= wdata;
            if (rev_load)   datar_q <= rev_data;
            if (emit)       out_byte_q <= dataw_q;
            out_valid_q <= emit;
        end
    end

    // R5
    emit_single_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid_q |=> !out_valid_q);

    // R10
    rev_capture_chk: assert property (@(posedge clk) disable iff (rst)
        rev_load |=> datar_q == $past(rev_data));
endmodule

// File: rtl/lpt_regif.sv
module lpt_regif
    import lpt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [SEL_W-1:0]  bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic [BYTE_W-1:0] rev_data,
    input  logic              rev_load,
    output logic [BYTE_W-1:0] out_byte,
    output logic              out_valid,
    output logic              irq
);
    bus_op_t op;
    byte_t   status_q;
    byte_t   ctrl_q;
    byte_t   dataw_q;
    byte_t   datar_q;
    logic    pend_q;
    logic    emit;

    lpt_bus_decode u_dec (
        .addr (bus_addr),
        .we   (bus_we),
        .re   (bus_re),
        .op   (op)
    );

    lpt_handshake u_hs (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .wdata    (bus_wdata),
        .status_q (status_q),
        .ctrl_q   (ctrl_q),
        .pend_q   (pend_q),
        .emit     (emit)
    );

    lpt_datapath u_dp (
        .clk         (clk),
        .rst         (rst),
        .op          (op),
        .wdata       (bus_wdata),
        .rev_data    (rev_data),
        .rev_load    (rev_load),
        .emit        (emit),
        .dataw_q     (dataw_q),
        .datar_q     (datar_q),
        .out_byte_q  (out_byte),
        .out_valid_q (out_valid)
    );

    always_comb begin
        case (bus_addr)
            SEL_DATA: bus_rdata = ctrl_q[CT_DIR] ? datar_q : dataw_q;
            SEL_STAT: bus_rdata = status_q;
            SEL_CTRL: bus_rdata = ctrl_q;
            default:  bus_rdata = UNMAPPED;
        endcase
    end

    assign irq = pend_q;

    // R2
    unmapped_read_chk: assert property (@(posedge clk) disable iff (rst)
        bus_addr > SEL_CTRL |-> bus_rdata == UNMAPPED);

    // R3
    ctrl_fixed_chk: assert property (@(posedge clk) disable iff (rst)
        bus_addr == SEL_CTRL |-> bus_rdata[7:6] == 2'b11);

    // R9
    irq_drop_chk: assert property (@(posedge clk) disable iff (rst)
        bus_re && bus_addr == SEL_STAT |=> !irq);
endmodule

// File: tb/lpt_regif_tb.sv
module lpt_regif_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_we = 1'b0;
    logic       bus_re = 1'b0;
    logic [7:0] bus_rdata;
    logic [7:0] rev_data = '0;
    logic       rev_load = 1'b0;
    logic [7:0] out_byte;
    logic       out_valid;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    lpt_regif u_dut (
        .clk (clk), .rst (rst),
        .bus_addr (bus_addr), .bus_wdata (bus_wdata),
        .bus_we (bus_we), .bus_re (bus_re), .bus_rdata (bus_rdata),
        .rev_data (rev_data), .rev_load (rev_load),
        .out_byte (out_byte), .out_valid (out_valid), .irq (irq)
    );

    // {we, re, addr[3], wdata[8], chk, exp_rd[8], exp_irq, exp_ov, req[4]}
    localparam int NV = 30;
    localparam logic [27:0] VEC [NV] = '{
        {1'b0,1'b1,3'd1,8'h00,1'b1,8'hD9,1'b0,1'b0,4'd1},  // R1 status
        {1'b0,1'b1,3'd2,8'h00,1'b1,8'hCC,1'b0,1'b0,4'd1},  // R1 control
        {1'b0,1'b1,3'd0,8'h00,1'b1,8'hFF,1'b0,1'b0,4'd1},  // R1 data
        {1'b0,1'b1,3'd3,8'h00,1'b1,8'hFF,1'b0,1'b0,4'd2},  // R2 offset 3
        {1'b0,1'b1,3'd7,8'h00,1'b1,8'hFF,1'b0,1'b0,4'd2},  // R2 offset 7
        {1'b1,1'b0,3'd0,8'h5A,1'b0,8'h00,1'b0,1'b0,4'd2},  // R2 data write
        {1'b0,1'b1,3'd0,8'h00,1'b1,8'h5A,1'b0,1'b0,4'd7},  // R7 output direction
        {1'b1,1'b0,3'd2,8'h1C,1'b0,8'h00,1'b0,1'b0,4'd3},  // R3 enable irq
        {1'b0,1'b1,3'd2,8'h00,1'b1,8'hDC,1'b0,1'b0,4'd3},  // R3 forced bits
        {1'b1,1'b0,3'd2,8'h1C,1'b0,8'h00,1'b0,1'b0,4'd6},  // R6 strobe with enable
        {1'b0,1'b1,3'd1,8'h00,1'b1,8'hD9,1'b1,1'b0,4'd9},  // R9 irq high
        {1'b0,1'b1,3'd2,8'h00,1'b1,8'hDC,1'b0,1'b0,4'd8},  // R8 cleared
        {1'b1,1'b0,3'd2,8'h1D,1'b0,8'h00,1'b0,1'b0,4'd5},  // R5 release
        {1'b0,1'b1,3'd1,8'h00,1'b1,8'h59,1'b0,1'b1,4'd5},  // R5 busy clear, pulse
        {1'b0,1'b1,3'd1,8'h00,1'b1,8'h59,1'b0,1'b0,4'd5},  // R5 one clock only
        {1'b1,1'b0,3'd2,8'h1C,1'b0,8'h00,1'b0,1'b0,4'd6},  // R6 strobe again
        {1'b0,1'b1,3'd1,8'h00,1'b1,8'h59,1'b1,1'b0,4'd8},  // R8 read, ack drops
        {1'b0,1'b1,3'd1,8'h00,1'b1,8'h19,1'b0,1'b0,4'd8},  // R8 ack and busy rise
        {1'b0,1'b1,3'd1,8'h00,1'b1,8'hD9,1'b0,1'b0,4'd8},  // R8 stable when busy
        {1'b1,1'b0,3'd2,8'h08,1'b0,8'h00,1'b0,1'b0,4'd4},  // R4 init low
        {1'b0,1'b1,3'd1,8'h00,1'b1,8'hD8,1'b0,1'b0,4'd4},  // R4 reload
        {1'b0,1'b1,3'd2,8'h00,1'b1,8'hC8,1'b0,1'b0,4'd3},  // R3 stored
        {1'b1,1'b0,3'd1,8'h00,1'b0,8'h00,1'b0,1'b0,4'd2},  // R2 status write
        {1'b0,1'b1,3'd1,8'h00,1'b1,8'hD8,1'b0,1'b0,4'd2},  // R2 ignored
        {1'b1,1'b0,3'd6,8'h00,1'b0,8'h00,1'b0,1'b0,4'd2},  // R2 unmapped write
        {1'b0,1'b1,3'd0,8'h00,1'b1,8'h5A,1'b0,1'b0,4'd2},  // R2 data intact
        {1'b1,1'b0,3'd2,8'h0C,1'b0,8'h00,1'b0,1'b0,4'd6},  // R6 no enable stored
        {1'b0,1'b1,3'd2,8'h00,1'b1,8'hCC,1'b0,1'b0,4'd6},  // R6 no irq
        {1'b1,1'b0,3'd2,8'h2C,1'b0,8'h00,1'b0,1'b0,4'd7},  // R7 input direction
        {1'b0,1'b1,3'd0,8'h00,1'b1,8'hFF,1'b0,1'b0,4'd7}   // R7 latch at reset
    };

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic access(logic we, logic re, logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        bus_we = we; bus_re = re; bus_addr = a; bus_wdata = d;
        #1;
    endtask

    task automatic idle();
        @(negedge clk);
        bus_we = 1'b0; bus_re = 1'b0; rev_load = 1'b0;
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            logic [27:0] v;
            v = VEC[i];
            access(v[27], v[26], v[25:23], v[22:15]);
            checks++;
            if (irq !== v[5] || out_valid !== v[4]) begin
                errors++;
                $display("FAIL R%0d vec %0d: irq/ov got %b%b expected %b%b",
                         v[3:0], i, irq, out_valid, v[5], v[4]);
            end
            if (v[14]) begin
                checks++;
                if (bus_rdata !== v[13:6]) begin
                    errors++;
                    $display("FAIL R%0d vec %0d: rdata got %02h expected %02h",
                             v[3:0], i, bus_rdata, v[13:6]);
                end
            end
        end

        // R5: byte on the output bus on release
        access(1'b1, 1'b0, 3'd0, 8'hA5);
        access(1'b1, 1'b0, 3'd2, 8'h2D);
        idle();
        check("R5 valid", {7'd0, out_valid}, 8'h01);
        check("R5 byte", out_byte, 8'hA5);
        idle();
        check("R5 valid drop", {7'd0, out_valid}, 8'h00);

        // R10: load coinciding with an input-direction data read
        @(negedge clk);
        bus_we = 1'b0; bus_re = 1'b1; bus_addr = 3'd0;
        rev_data = 8'h3C; rev_load = 1'b1;
        #1;
        check("R10 same cycle old byte", bus_rdata, 8'hFF);
        @(negedge clk);
        rev_load = 1'b0; rev_data = 8'h00;
        #1;
        check("R10 new byte", bus_rdata, 8'h3C);
        idle();
        access(1'b0, 1'b1, 3'd0, 8'h00);
        check("R10 held", bus_rdata, 8'h3C);

        // R5 and R6 with select low: no emit, no pending
        access(1'b1, 1'b0, 3'd2, 8'h14);
        access(1'b1, 1'b0, 3'd2, 8'h14);
        idle();
        check("R6 select low no irq", {7'd0, irq}, 8'h00);
        access(1'b1, 1'b0, 3'd2, 8'h15);
        idle();
        check("R5 select low no pulse", {7'd0, out_valid}, 8'h00);
        access(1'b0, 1'b1, 3'd1, 8'h00);
        check("R5 select low status", bus_rdata, 8'h58);

        // R1: reset in mid-run
        @(negedge clk);
        bus_we = 1'b0; bus_re = 1'b0; rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        bus_re = 1'b1; bus_addr = 3'd1;
        #1;
        check("R1 status", bus_rdata, 8'hD9);
        bus_addr = 3'd2;
        #1;
        check("R1 control", bus_rdata, 8'hCC);
        bus_addr = 3'd0;
        #1;
        check("R1 data", bus_rdata, 8'hFF);
        check("R1 irq", {7'd0, irq}, 8'h00);
        check("R1 out_valid", {7'd0, out_valid}, 8'h00);
        idle();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule